// File: doc/BRIEF.md
# Watchdog Timer with Interrupt or Reset Steering

This block is a programmable watchdog. Software loads an 8-bit setting into a configuration register. The setting holds a 2-bit resolution, a 5-bit multiplier and a steering bit. The block then counts whole periods of an external enable strobe `tick_i`, which the system drives once every 1/16 s. If the count completes before software restarts it, the watchdog expires.

On expiry the block sets a sticky timeout flag. The steering bit selects what happens next:
- With the steering bit clear, the block raises a one-cycle interrupt pulse.
- With the steering bit set, the block raises a one-cycle system-reset request. It also wipes the configuration register and drops a keep bit held in a small control register.

Software restarts the count in either of two ways: by writing the configuration register, or by reading the flags register. Both clear the timeout flag. After an expiry the count stays idle until one of these restarts happens.

Access is through a plain byte register port. Each access completes in a single cycle and there is no back-pressure: `req_wr_i` and `req_rd_i` are one-cycle strobes that are always accepted. Read data appears on `rsp_rdata_o` after the next clock edge and holds until the next read.

Top module: `wdog_steer`

## Requirements
- R1: After reset, all four register addresses read 0x00, and `irq_o` and `sys_rst_req_o` are low.
- R2: Only cycles with `tick_i` high count. With resolution r (config bits [1:0]) and multiplier m (config bits [6:2]), expiry happens on exactly the (m << 2r)-th tick after a restart and never earlier.
- R3: Writing address 1 (configuration) stores the byte so that it reads back, clears the timeout flag, and restarts the count with the new interval, discarding any count in progress.
- R4: Reading address 0 (flags) returns the flag value from before the read. The read then clears the flag and restarts the count from the interval of the current configuration.
- R5: Expiry sets bit 7 of the flags register. All other flag bits read 0.
- R6: Expiry with config bit 7 (steering) set gives a single-cycle `sys_rst_req_o` pulse with `irq_o` low. In the same cycle the configuration register becomes 0x00 and control bit 6 becomes 0.
- R7: Expiry with the steering bit clear gives a single-cycle `irq_o` pulse with `sys_rst_req_o` low. The configuration and control registers keep their values.
- R8: Writes to address 0 are ignored: they change neither the flag nor the count.
- R9: A multiplier of zero leaves the count idle, so no expiry occurs for any resolution or steering value.
- R10: After an expiry the count stays stopped, and further ticks cause no event until the next restart.
- R11: Address 2 (control) stores bit 6 only. Its other bits read 0.
- R12: Read data is registered: it appears after the clock edge that samples `req_rd_i`. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Enable strobe, one per 1/16 s |
| req_wr_i | input | 1 | Register write strobe |
| req_rd_i | input | 1 | Register read strobe |
| req_addr_i | input | 2 | Register address |
| req_wdata_i | input | 8 | Write data |
| rsp_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | One-cycle interrupt pulse on expiry (steering clear) |
| sys_rst_req_o | output | 1 | One-cycle system-reset request on expiry (steering set) |

## Verification
An expiry is caused by the tick that completes the interval. Its effects (the event pulse, the flag and the register wipe) all become visible right after that same tick's clock edge. The pulse drops at the following edge. A register write or a restart read takes effect at the edge that samples it, and read data is valid after that edge. The bench therefore drives each strobe for one full cycle starting at a falling edge, and samples at the next falling edge, one rising edge later. It counts ticks itself to know which tick must be the expiring one. It sweeps every resolution with every multiplier against the interval computed arithmetically.

// File: rtl/wdog_steer_pkg.sv
package wdog_steer_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int RES_W    = 2;
  localparam int MULT_W   = 5;
  // widest interval: multiplier shifted by twice the largest resolution
  localparam int CNT_W    = MULT_W + 2 * ((1 << RES_W) - 1);
  localparam int FLAG_BIT = 7;
  localparam int KEEP_BIT = 6;

  typedef enum logic [ADDR_W-1:0] {
    ADR_FLAGS = 2'd0,
    ADR_WDOG  = 2'd1,
    ADR_CTRL  = 2'd2,
    ADR_SPARE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic              steer;
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
  } wdog_cfg_t;
endpackage

// File: rtl/wdog_interval.sv
module wdog_interval
  import wdog_steer_pkg::*;
#(
  parameter int RW = RES_W,
  parameter int MW = MULT_W,
  parameter int CW = MW + 2 * ((1 << RW) - 1)
) (
  input  logic [RW-1:0] res_i,
  input  logic [MW-1:0] mult_i,
  output logic [CW-1:0] ticks_o
);
  localparam int NRES = 1 << RW;

  logic [CW-1:0] scaled [NRES];

  // one shifted copy of the multiplier per resolution step (x4 each)
  for (genvar r = 0; r < NRES; r++) begin : g_scale
    assign scaled[r] = CW'(mult_i) << (2 * r);
  end

  assign ticks_o = scaled[res_i];
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
  parameter int CW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          restart_i,
  input  logic [CW-1:0] load_i,
  output logic          expire_o,
  output logic          armed_o
);
  logic [CW-1:0] cnt_q;
  logic          armed_q;

  // the tick that meets the last remaining unit expires, unless a restart wins
  assign expire_o = armed_q && tick_i && !restart_i && (cnt_q == CW'(1));
  assign armed_o  = armed_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q   <= load_i;
      armed_q <= (load_i != '0);
    end else if (expire_o) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (armed_q && tick_i) begin
      cnt_q   <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_steer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              expire_i,
  output logic              restart_o,
  output wdog_cfg_t         load_cfg_o,
  output wdog_cfg_t         cfg_o,
  output logic              flag_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  wdog_cfg_t         cfg_q;
  logic              flag_q, keep_q, irq_q, rst_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  logic              wr_cfg, wr_ctrl, rd_flags, steer_hit;

  assign wr_cfg    = wr_i && (addr_i == ADR_WDOG);
  assign wr_ctrl   = wr_i && (addr_i == ADR_CTRL);
  assign rd_flags  = rd_i && (addr_i == ADR_FLAGS);
  assign restart_o = wr_cfg || rd_flags;
  // a write supplies the new interval; a kick reuses the stored one
  assign load_cfg_o = wr_cfg ? wdog_cfg_t'(wdata_i) : cfg_q;
  assign steer_hit  = expire_i && cfg_q.steer;

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      ADR_FLAGS: rd_mux[FLAG_BIT] = flag_q;
      ADR_WDOG:  rd_mux           = cfg_q;
      ADR_CTRL:  rd_mux[KEEP_BIT] = keep_q;
      default:   rd_mux           = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      flag_q  <= 1'b0;
      keep_q  <= 1'b0;
      irq_q   <= 1'b0;
      rst_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (restart_o)     flag_q <= 1'b0;
      else if (expire_i) flag_q <= 1'b1;

      if (wr_cfg)         cfg_q <= wdog_cfg_t'(wdata_i);
      else if (steer_hit) cfg_q <= '0;

      if (steer_hit)    keep_q <= 1'b0;
      else if (wr_ctrl) keep_q <= wdata_i[KEEP_BIT];

      irq_q <= expire_i && !cfg_q.steer;
      rst_q <= steer_hit;

      if (rd_i) rdata_q <= rd_mux;
    end
  end

  assign cfg_o     = cfg_q;
  assign flag_o    = flag_q;
  assign rdata_o   = rdata_q;
  assign irq_o     = irq_q;
  assign rst_req_o = rst_q;
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer
  import wdog_steer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_wr_i,
  input  logic              req_rd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              irq_o,
  output logic              sys_rst_req_o
);
  wdog_cfg_t        load_cfg, cfg_q;
  logic             restart, expire, armed, flag_q;
  logic [CNT_W-1:0] load_ticks;

  wdog_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (req_wr_i),
    .rd_i       (req_rd_i),
    .addr_i     (req_addr_i),
    .wdata_i    (req_wdata_i),
    .expire_i   (expire),
    .restart_o  (restart),
    .load_cfg_o (load_cfg),
    .cfg_o      (cfg_q),
    .flag_o     (flag_q),
    .rdata_o    (rsp_rdata_o),
    .irq_o      (irq_o),
    .rst_req_o  (sys_rst_req_o)
  );

  wdog_interval #(.RW(RES_W), .MW(MULT_W), .CW(CNT_W)) u_interval (
    .res_i   (load_cfg.res),
    .mult_i  (load_cfg.mult),
    .ticks_o (load_ticks)
  );

  wdog_countdown #(.CW(CNT_W)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .restart_i (restart),
    .load_i    (load_ticks),
    .expire_o  (expire),
    .armed_o   (armed)
  );
endmodule

// File: rtl/wdog_steer_chk.sv
module wdog_steer_chk
  import wdog_steer_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_o,
  input logic              sys_rst_req_o,
  input logic              flag_q,
  input logic              armed,
  input logic [DATA_W-1:0] cfg_bits,
  input logic              req_wr_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [MULT_W-1:0] wr_mult
);
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R7
  AST_RST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |=> !sys_rst_req_o); // R6
  AST_EVT_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && sys_rst_req_o)); // R6
  AST_FLAG_WITH_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || sys_rst_req_o) |-> flag_q); // R5
  AST_RST_WIPES_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |-> (cfg_bits == '0)); // R6
  AST_WR_CLEARS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_wr_i && req_addr_i == ADR_WDOG) |=> !flag_q); // R3
  AST_ZERO_MULT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_wr_i && req_addr_i == ADR_WDOG && wr_mult == '0) |=> !armed); // R9
  AST_STOP_AFTER_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || sys_rst_req_o) |-> !armed); // R10
endmodule

bind wdog_steer wdog_steer_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .irq_o         (irq_o),
  .sys_rst_req_o (sys_rst_req_o),
  .flag_q        (flag_q),
  .armed         (armed),
  .cfg_bits      (cfg_q),
  .req_wr_i      (req_wr_i),
  .req_addr_i    (req_addr_i),
  .wr_mult       (req_wdata_i[6:2])
);

// File: tb/wdog_steer_tb_top.sv
module wdog_steer_tb_top;
  import wdog_steer_pkg::*;
  localparam time CLK_PERIOD = 10;
  localparam int  WD_LIMIT   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, sreq;
  int         checks = 0, errors = 0;
  int         cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_steer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_wr_i(wr), .req_rd_i(rd),
    .req_addr_i(addr), .req_wdata_i(wdata), .rsp_rdata_o(rdata),
    .irq_o(irq), .sys_rst_req_o(sreq)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
      summary();
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic tick_once(output logic i, output logic r);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; i = irq; r = sreq;
  endtask

  // n ticks; returns 1 if any event was seen
  task automatic ticks(int n, output logic any);
    logic i, r;
    any = 1'b0;
    for (int k = 0; k < n; k++) begin tick_once(i, r); any |= i | r; end
  endtask

  task automatic run_case(int res, int mult, bit steer);
    logic [7:0] val, d;
    int   ival;
    logic early, fi, fr, i, r, any;
    val  = {steer, 5'(mult), 2'(res)};
    ival = mult << (2 * res);
    early = 1'b0; fi = 1'b0; fr = 1'b0;
    wr_reg(ADR_CTRL, 8'h40);
    wr_reg(ADR_WDOG, val);
    for (int k = 1; k <= ival; k++) begin
      tick_once(i, r);
      if (k < ival) early |= i | r;
      else begin fi = i; fr = r; end
    end
    chk("R2", $sformatf("no early event cfg=%02h", val), int'(early), 0);
    chk(steer ? "R6" : "R7", $sformatf("irq at expiry cfg=%02h", val), int'(fi), int'(!steer));
    chk(steer ? "R6" : "R7", $sformatf("rst at expiry cfg=%02h", val), int'(fr), int'(steer));
    @(negedge clk);
    chk(steer ? "R6" : "R7", "pulse lasts one cycle", int'({irq, sreq}), 0);
    ticks(2, any);
    chk("R10", $sformatf("stopped after expiry cfg=%02h", val), int'(any), 0);
    rd_reg(ADR_WDOG, d);
    chk(steer ? "R6" : "R7", "config after expiry", int'(d), steer ? 0 : int'(val));
    rd_reg(ADR_CTRL, d);
    chk(steer ? "R6" : "R7", "control bit 6 after expiry", int'(d), steer ? 0 : 'h40);
    rd_reg(ADR_FLAGS, d);
    chk("R5", "flag bit 7 after expiry", int'(d), 'h80);
  endtask

  initial begin
    logic [7:0] d;
    logic i, r, any;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1", "outputs idle", int'({irq, sreq}), 0);
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), d);
      chk("R1", $sformatf("reset value addr %0d", a), int'(d), 0);
    end

    // R11 control register keeps only bit 6
    wr_reg(ADR_CTRL, 8'hFF); rd_reg(ADR_CTRL, d);
    chk("R11", "control readback ff", int'(d), 'h40);
    wr_reg(ADR_CTRL, 8'hBF); rd_reg(ADR_CTRL, d);
    chk("R11", "control readback bf", int'(d), 0);

    // R12 spare address and read latency
    rd_reg(ADR_SPARE, d);
    chk("R12", "spare address", int'(d), 0);

    // R2 idle cycles without tick do not count
    wr_reg(ADR_WDOG, 8'h04);
    any = 1'b0;
    for (int k = 0; k < 5; k++) begin @(negedge clk); any |= irq | sreq; end
    chk("R2", "no expiry without ticks", int'(any), 0);
    tick_once(i, r);
    chk("R2", "expiry on first tick", int'(i), 1);

    // R3 rewrite mid-count restarts with new interval
    wr_reg(ADR_WDOG, 8'h10);
    ticks(3, any);
    wr_reg(ADR_WDOG, 8'h0C);
    rd_reg(ADR_WDOG, d);
    chk("R3", "config readback", int'(d), 'h0C);
    ticks(2, any);
    chk("R3", "no event before new interval", int'(any), 0);
    tick_once(i, r);
    chk("R3", "event after new interval", int'(i), 1);

    // R4 reading flags kicks and clears
    wr_reg(ADR_WDOG, 8'h10);
    ticks(3, any);
    rd_reg(ADR_FLAGS, d);
    chk("R4", "flags before expiry", int'(d), 0);
    ticks(3, any);
    chk("R4", "kick restarted count", int'(any), 0);
    tick_once(i, r);
    chk("R4", "expiry after kick interval", int'(i), 1);
    rd_reg(ADR_FLAGS, d);
    chk("R4", "flag read returns old value", int'(d), 'h80);
    rd_reg(ADR_FLAGS, d);
    chk("R4", "flag cleared by read", int'(d), 0);

    // R8 flags register ignores writes
    wr_reg(ADR_WDOG, 8'h04);
    tick_once(i, r);
    wr_reg(ADR_FLAGS, 8'h00);
    rd_reg(ADR_FLAGS, d);
    chk("R8", "write 00 left flag set", int'(d), 'h80);
    wr_reg(ADR_FLAGS, 8'hFF);
    rd_reg(ADR_FLAGS, d);
    chk("R8", "write ff did not set flag", int'(d), 0);

    // R9 zero multiplier never expires
    wr_reg(ADR_WDOG, 8'h03);
    ticks(40, any);
    chk("R9", "no expiry res3 mult0", int'(any), 0);
    wr_reg(ADR_WDOG, 8'h80);
    ticks(40, any);
    chk("R9", "no expiry steer mult0", int'(any), 0);
    rd_reg(ADR_FLAGS, d);
    chk("R9", "flag stays clear", int'(d), 0);

    // sweep: every resolution and multiplier, interrupt steering
    for (int rs = 0; rs < 4; rs++)
      for (int m = 1; m < 32; m++) run_case(rs, m, 1'b0);
    // reset steering over the two finer resolutions
    for (int rs = 0; rs < 2; rs++)
      for (int m = 1; m < 32; m++) run_case(rs, m, 1'b1);

    summary();
  end
endmodule